// File: doc/BRIEF.md
# DDR3 Burst Column Order Generator

This block turns a DRAM column command into the per-beat column offsets of its data burst. A memory controller or memory model pulses `cmd_valid` together with the low three column bits, the read/write direction, the burst-chop request bit and the two mode settings (length mode and burst type). On the following cycle the block begins presenting one beat per clock for eight clocks: the beat number, the column offset that beat carries, and a flag marking the slots in which a chopped read must keep its data and strobe drivers in high impedance.

Reads follow the programmed burst type. In sequential order the count wraps inside the 4-beat half that holds the start column, and the other half follows in the same pattern. In interleaved order each offset is the start column XOR the beat number. Writes ignore the low start bits. A full write always counts 0 to 7. A chopped write uses only column bit 2 to pick the lower or upper half.

The controller sits in one of two states: `ST_IDLE` and `ST_BURST`. Transition *launch* (`ST_IDLE` to `ST_BURST`) is taken on a command. Transition *chain* (`ST_BURST` to `ST_BURST` at the last beat) is taken when a command is waiting in the one-entry slot or arrives on that edge. Transition *drain* (`ST_BURST` to `ST_IDLE` at the last beat) is taken when nothing waits. Commands that arrive mid-burst are held in the slot, so bursts follow each other with no idle cycle.

Top module: `ddr3_burst_order`

## Requirements
- R1: While reset is held, and whenever no burst runs, `beat_valid` and `beat_hiz` are 0, and `beat_offset` and `beat_idx` are 0.
- R2: A command sampled on a clock edge with no burst running makes `beat_valid` rise on that edge. It then stays high for exactly eight cycles, with `beat_idx` stepping 0,1,...,7.
- R3: A full-length read with burst type 0 (sequential) gives offset = {s[2] XOR i[2], (s[1:0] + i[1:0]) mod 4} for start column s and beat i. Start 1 gives 1,2,3,0,5,6,7,4, and start 7 gives 7,4,5,6,3,0,1,2.
- R4: A full-length read with burst type 1 (interleaved) gives offset = s XOR i. Start 5 gives 5,4,7,6,1,0,3,2.
- R5: A full-length write gives offset = i (0 through 7) for any start column and either burst type.
- R6: A chopped read gives the same offsets as the full-length read in beats 0-3. `beat_hiz` is 1 in beats 4-7 and 0 in every other slot.
- R7: A chopped write gives offset {c2 XOR i[2], i[1:0]}, where c2 is column bit 2. That is 0,1,2,3 then 4,5,6,7 when c2=0, and 4,5,6,7 then 0,1,2,3 when c2=1. `beat_hiz` stays 0.
- R8: Length mode `mode_len` is sampled with the command. 2'b00 means fixed full length, 2'b10 means fixed chop, and 2'b01 means on-the-fly, where `cmd_a12` low chops and high gives full length. 2'b11 acts as full length. `cmd_a12` is ignored in both fixed modes.
- R9: The burst type `mode_interleave` (0 sequential, 1 interleaved) is sampled with each command and applies to that burst only.
- R10: A command sampled while a burst runs and the slot is empty starts on the edge right after the current burst's last beat, with no gap cycle.
- R11: A command sampled while a burst runs and the slot already holds one is discarded.
- R12: A command sampled on the edge that ends a burst starts directly on that edge when the slot is empty. When the slot is full, the held command starts and the new one takes the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Read or write command pulse |
| cmd_write | input | 1 | 1 for write, 0 for read |
| cmd_a12 | input | 1 | On-the-fly chop request, low means chop |
| cmd_col | input | 3 | Low three column address bits |
| mode_len | input | 2 | Burst length mode, encoding as in R8 |
| mode_interleave | input | 1 | Burst type, 0 sequential, 1 interleaved |
| beat_valid | output | 1 | A beat slot is being presented |
| beat_idx | output | 3 | Beat number within the burst |
| beat_offset | output | 3 | Column offset carried by this beat |
| beat_hiz | output | 1 | Chopped-read slot with drivers in high impedance |

## Verification
The bench checks the wrap inside each half for sequential starts 1 and 7 and the XOR order for interleaved start 5. A design that counted linearly through eight beats, or that swapped the two burst types, would fail those offsets. It checks chopped reads and writes with column bit 2 both clear and set, which catches a tri-state flag placed on the wrong half and a write that keeps the low start bits. It checks that `cmd_a12` has no effect in the fixed length modes. It issues commands mid-burst, on the final edge, and with the slot already full. A slot that dropped the held command, let the newest one overwrite it, or inserted a bubble between bursts would show a wrong offset or a low `beat_valid` in the expected slot.

// File: rtl/bo_pkg.sv
package bo_pkg;
    localparam int BEAT_W = 3;
    localparam int BEATS  = 1 << BEAT_W;
    localparam int HALF_W = BEAT_W - 1;

    typedef enum logic [1:0] {
        LEN_FIXED_FULL = 2'b00,
        LEN_ON_THE_FLY = 2'b01,
        LEN_FIXED_CHOP = 2'b10,
        LEN_RESERVED   = 2'b11
    } len_mode_e;

    typedef enum logic {
        ST_IDLE,
        ST_BURST
    } seq_state_e;

    typedef struct packed {
        logic              wr;
        logic              chop;
        logic              itlv;
        logic [BEAT_W-1:0] col;
    } burst_cmd_t;
endpackage

// File: rtl/bo_cmd_decode.sv
module bo_cmd_decode
    import bo_pkg::*;
(
    input  logic              write_i,
    input  logic              a12_i,
    input  logic [1:0]        len_i,
    input  logic              itlv_i,
    input  logic [BEAT_W-1:0] col_i,
    output burst_cmd_t        cmd_o
);
    logic chop;

    always_comb begin
        unique case (len_mode_e'(len_i))
            LEN_FIXED_CHOP: chop = 1'b1;
            LEN_ON_THE_FLY: chop = ~a12_i;
            LEN_FIXED_FULL: chop = 1'b0;
            LEN_RESERVED:   chop = 1'b0;
        endcase
    end

    assign cmd_o.wr   = write_i;
    assign cmd_o.chop = chop;
    assign cmd_o.itlv = itlv_i;
    assign cmd_o.col  = col_i;
endmodule

// File: rtl/bo_beat_map.sv
module bo_beat_map
    import bo_pkg::*;
(
    input  burst_cmd_t        cmd_i,
    input  logic [BEAT_W-1:0] idx_i,
    output logic [BEAT_W-1:0] offset_o,
    output logic              hiz_o
);
    logic [HALF_W-1:0] seq_low;
    logic [BEAT_W-1:0] xor_ord;
    logic [BEAT_W-1:0] seq_ord;
    logic [BEAT_W-1:0] wr_ord;
    logic              wr_half;

    // interleaved: bitwise XOR of start and beat number
    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
        assign xor_ord[b] = cmd_i.col[b] ^ idx_i[b];
    end

    // sequential: wrap inside the half, halves alternate by the top bit
    assign seq_low = cmd_i.col[HALF_W-1:0] + idx_i[HALF_W-1:0];
    assign seq_ord = {cmd_i.col[BEAT_W-1] ^ idx_i[BEAT_W-1], seq_low};

    // writes: only the top column bit of a chopped burst is honoured
    assign wr_half = cmd_i.chop & cmd_i.col[BEAT_W-1];
    assign wr_ord  = {wr_half ^ idx_i[BEAT_W-1], idx_i[HALF_W-1:0]};

    always_comb begin
        if (cmd_i.wr) begin
            offset_o = wr_ord;
        end else if (cmd_i.itlv) begin
            offset_o = xor_ord;
        end else begin
            offset_o = seq_ord;
        end
        hiz_o = ~cmd_i.wr & cmd_i.chop & idx_i[BEAT_W-1];
    end
endmodule

// File: rtl/bo_pend_slot.sv
module bo_pend_slot
    import bo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       pop_i,
    input  burst_cmd_t cmd_i,
    output logic       full_o,
    output burst_cmd_t cmd_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_o <= 1'b0;
            cmd_o  <= '0;
        end else begin
            if (load_i) begin
                full_o <= 1'b1;
                cmd_o  <= cmd_i;
            end else if (pop_i) begin
                full_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ddr3_burst_order.sv
module ddr3_burst_order
    import bo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic              cmd_a12,
    input  logic [BEAT_W-1:0] cmd_col,
    input  logic [1:0]        mode_len,
    input  logic              mode_interleave,
    output logic              beat_valid,
    output logic [BEAT_W-1:0] beat_idx,
    output logic [BEAT_W-1:0] beat_offset,
    output logic              beat_hiz
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    seq_state_e        state_q, state_d;
    logic [BEAT_W-1:0] idx_q, idx_d;
    burst_cmd_t        cur_q, cur_d;
    burst_cmd_t        dec_cmd, src_cmd, slot_cmd;
    logic              slot_full, slot_load, slot_pop;
    logic              launch, last_beat;
    logic [BEAT_W-1:0] off_d;
    logic              hiz_d;

    bo_cmd_decode u_dec (
        .write_i (cmd_write),
        .a12_i   (cmd_a12),
        .len_i   (mode_len),
        .itlv_i  (mode_interleave),
        .col_i   (cmd_col),
        .cmd_o   (dec_cmd)
    );

    bo_pend_slot u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (slot_load),
        .pop_i  (slot_pop),
        .cmd_i  (dec_cmd),
        .full_o (slot_full),
        .cmd_o  (slot_cmd)
    );

    assign last_beat = (idx_q == LAST_BEAT);
    assign src_cmd   = slot_full ? slot_cmd : dec_cmd;

    always_comb begin
        launch    = 1'b0;
        slot_load = 1'b0;
        slot_pop  = 1'b0;
        state_d   = state_q;
        idx_d     = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                launch  = cmd_valid;
                state_d = cmd_valid ? ST_BURST : ST_IDLE;
            end
            ST_BURST: begin
                launch    = last_beat & (slot_full | cmd_valid);
                slot_pop  = last_beat & slot_full;
                slot_load = cmd_valid & (last_beat ? slot_full : ~slot_full);
                if (last_beat) begin
                    state_d = launch ? ST_BURST : ST_IDLE;
                end
                idx_d = idx_q + 1'b1;
            end
        endcase
        if (launch) begin
            idx_d = '0;
        end
        cur_d = launch ? src_cmd : cur_q;
    end

    bo_beat_map u_map (
        .cmd_i    (cur_d),
        .idx_i    (idx_d),
        .offset_o (off_d),
        .hiz_o    (hiz_d)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            cur_q   <= cur_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_valid  <= 1'b0;
            beat_idx    <= '0;
            beat_offset <= '0;
            beat_hiz    <= 1'b0;
        end else begin
            beat_valid  <= (state_d == ST_BURST);
            beat_idx    <= (state_d == ST_BURST) ? idx_d : '0;
            beat_offset <= (state_d == ST_BURST) ? off_d : '0;
            beat_hiz    <= (state_d == ST_BURST) & hiz_d;
        end
    end
endmodule

// File: rtl/bo_checker.sv
module bo_checker
    import bo_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              beat_valid,
    input logic [BEAT_W-1:0] beat_idx,
    input logic [BEAT_W-1:0] beat_offset,
    input logic              beat_hiz
);
    localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |-> (beat_offset == '0 && beat_idx == '0 && !beat_hiz));

    a_r2_start_next: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_valid && cmd_valid) |=> (beat_valid && beat_idx == '0));

    a_r2_first_beat_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_valid) |-> (beat_idx == '0));

    a_r2_beats_step: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_idx != LAST) |=>
            (beat_valid && beat_idx == $past(beat_idx) + 1'b1));

    a_r6_hiz_upper_slots: assert property (@(posedge clk) disable iff (!rst_n)
        beat_hiz |-> (beat_valid && beat_idx[BEAT_W-1]));

    a_r12_direct_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_idx == LAST && cmd_valid) |=>
            (beat_valid && beat_idx == '0));
endmodule

bind ddr3_burst_order bo_checker u_bo_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .beat_valid  (beat_valid),
    .beat_idx    (beat_idx),
    .beat_offset (beat_offset),
    .beat_hiz    (beat_hiz)
);

// File: tb/ddr3_burst_order_bench.sv
module ddr3_burst_order_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_write = 1'b0;
    logic       cmd_a12 = 1'b1;
    logic [2:0] cmd_col = '0;
    logic [1:0] mode_len = '0;
    logic       mode_interleave = 1'b0;
    logic       beat_valid;
    logic [2:0] beat_idx;
    logic [2:0] beat_offset;
    logic       beat_hiz;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ddr3_burst_order u_ddr3_burst_order (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_a12(cmd_a12), .cmd_col(cmd_col), .mode_len(mode_len),
        .mode_interleave(mode_interleave), .beat_valid(beat_valid),
        .beat_idx(beat_idx), .beat_offset(beat_offset), .beat_hiz(beat_hiz)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input bit v, input bit wr, input bit a12,
                         input logic [1:0] ml, input bit il, input logic [2:0] col);
        cmd_valid = v; cmd_write = wr; cmd_a12 = a12;
        mode_len = ml; mode_interleave = il; cmd_col = col;
    endtask

    function automatic bit is_chop(input logic [1:0] ml, input bit a12);
        return (ml == 2'b10) || (ml == 2'b01 && !a12);
    endfunction

    // expected offset from the requirement formulas (R3, R4, R5, R7)
    function automatic logic [2:0] exp_off(input bit wr, input bit chop, input bit il,
                                           input logic [2:0] s, input logic [2:0] i);
        logic [1:0] lo;
        if (wr) return chop ? {s[2] ^ i[2], i[1:0]} : i;
        if (il) return s ^ i;
        lo = s[1:0] + i[1:0];
        return {s[2] ^ i[2], lo};
    endfunction

    task automatic check_beat(input string req, input int i, input logic [2:0] eo, input bit eh);
        check(beat_valid === 1'b1, {req, " valid"}, int'(beat_valid), 1);
        check(beat_idx === 3'(i), {req, " idx"}, int'(beat_idx), i);
        check(beat_offset === eo, {req, " offset"}, int'(beat_offset), int'(eo));
        check(beat_hiz === eh, {req, " hiz"}, int'(beat_hiz), int'(eh));
    endtask

    // one command, optional literal list of offsets (beat 0 in the top bits)
    task automatic run_one(input string req, input bit wr, input bit a12, input logic [1:0] ml,
                           input bit il, input logic [2:0] col,
                           input bit use_lst, input logic [23:0] lst);
        bit chop;
        chop = is_chop(ml, a12);
        drive(1'b1, wr, a12, ml, il, col);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 3'd0);
        for (int i = 0; i < 8; i++) begin
            logic [2:0] eo;
            eo = use_lst ? lst[23-3*i -: 3] : exp_off(wr, chop, il, col, 3'(i));
            check_beat(req, i, eo, !wr && chop && i >= 4);
            @(negedge clk);
        end
        check(beat_valid === 1'b0, {req, " end R2"}, int'(beat_valid), 0);
        check(beat_offset === 3'd0, {req, " idle R1"}, int'(beat_offset), 0);
    endtask

    // three fixed commands A, B, C; B issued in slot tb, C in slot tc (-1 = never)
    task automatic run_chain(input string req, input int tb, input int tc, input int nseg);
        drive(1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 3'd1);          // A: seq read full, start 1
        @(negedge clk);
        for (int c = 0; c < 8 * nseg; c++) begin
            int seg;
            int i;
            seg = c / 8;
            i = c % 8;
            unique case (seg)
                0: check_beat(req, i, exp_off(1'b0, 1'b0, 1'b0, 3'd1, 3'(i)), 1'b0);
                1: check_beat(req, i, exp_off(1'b0, 1'b1, 1'b1, 3'd5, 3'(i)), i >= 4);
                default: check_beat(req, i, exp_off(1'b1, 1'b1, 1'b0, 3'd6, 3'(i)), 1'b0);
            endcase
            if (c == tb)      drive(1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 3'd5); // B: itlv read, otf chop
            else if (c == tc) drive(1'b1, 1'b1, 1'b1, 2'b10, 1'b0, 3'd6); // C: chopped write
            else              drive(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 3'd0);
            @(negedge clk);
        end
        check(beat_valid === 1'b0, {req, " drained"}, int'(beat_valid), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(beat_valid === 1'b0, "R1 reset valid", int'(beat_valid), 0);
        check(beat_hiz === 1'b0, "R1 reset hiz", int'(beat_hiz), 0);
        check(beat_offset === 3'd0, "R1 reset offset", int'(beat_offset), 0);
        check(beat_idx === 3'd0, "R1 reset idx", int'(beat_idx), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(beat_valid === 1'b0, "R1 idle after reset", int'(beat_valid), 0);

        run_one("R3 seq start1", 1'b0, 1'b1, 2'b00, 1'b0, 3'd1, 1'b1, {3'd1,3'd2,3'd3,3'd0,3'd5,3'd6,3'd7,3'd4});
        run_one("R3 seq start7", 1'b0, 1'b1, 2'b00, 1'b0, 3'd7, 1'b1, {3'd7,3'd4,3'd5,3'd6,3'd3,3'd0,3'd1,3'd2});
        run_one("R4 itlv start5", 1'b0, 1'b1, 2'b00, 1'b1, 3'd5, 1'b1, {3'd5,3'd4,3'd7,3'd6,3'd1,3'd0,3'd3,3'd2});
        run_one("R4 R9 itlv start2", 1'b0, 1'b1, 2'b00, 1'b1, 3'd2, 1'b0, 24'd0);
        run_one("R5 write itlv col5", 1'b1, 1'b1, 2'b00, 1'b1, 3'd5, 1'b1, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7});
        run_one("R5 write seq col3", 1'b1, 1'b1, 2'b00, 1'b0, 3'd3, 1'b0, 24'd0);
        run_one("R6 chop read seq col6", 1'b0, 1'b0, 2'b01, 1'b0, 3'd6, 1'b0, 24'd0);
        run_one("R6 chop read itlv col3", 1'b0, 1'b1, 2'b10, 1'b1, 3'd3, 1'b0, 24'd0);
        run_one("R7 chop write col3", 1'b1, 1'b0, 2'b01, 1'b0, 3'd3, 1'b1, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7});
        run_one("R7 chop write col5", 1'b1, 1'b1, 2'b10, 1'b1, 3'd5, 1'b1, {3'd4,3'd5,3'd6,3'd7,3'd0,3'd1,3'd2,3'd3});
        run_one("R8 fixed full ignores a12", 1'b0, 1'b0, 2'b00, 1'b0, 3'd2, 1'b0, 24'd0);
        run_one("R8 reserved acts full", 1'b0, 1'b0, 2'b11, 1'b0, 3'd4, 1'b0, 24'd0);
        run_one("R8 otf a12 high full", 1'b0, 1'b1, 2'b01, 1'b1, 3'd6, 1'b0, 24'd0);
        run_chain("R10 mid-burst chain", 3, -1, 2);
        run_chain("R11 full slot drops", 1, 2, 2);
        run_chain("R12 direct at last edge", 7, -1, 2);
        run_chain("R12 slot pop and refill", 2, 7, 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule